// File: doc/BRIEF.md
# Dual-Channel High/Low Width Pulse Generator

This block produces two rectangular pulse trains, each from a down counter that alternates between a LOW phase and a HIGH phase. Each phase length comes from its own reload register, so the two widths are set independently instead of being derived from a period and a duty value. The counters advance on a prescaled clock, picked from four divide ratios, and each output can be inverted.

Software programs the widths, the clock select, the operating mode and the polarity through a simple byte-wide write port. A channel is started either by writing its enable bit or by pulsing its external start input, and stopped by clearing the enable bit. In the wide mode, the two channels' reload registers are concatenated to time a single 16-bit pulse train on channel 0, while channel 1 is held at its idle level.

Top module: `pgen_pair`

## Requirements
- R1: After reset both outputs are low, every reload register holds 0, the clock select is 00, the mode is 00 and both channels are stopped. A channel started without any register writes therefore toggles every cycle.
- R2: Write address map: 0 = channel 0 LOW reload, 1 = channel 0 HIGH reload, 2 = channel 1 LOW reload, 3 = channel 1 HIGH reload, 4 = control, 5 = enable (bit 0 for channel 0, bit 1 for channel 1). When a channel starts, its output first shows the LOW phase, then the HIGH phase, and the two keep alternating.
- R3: With divide ratio D, reload values L and H, the LOW phase lasts D*(L+1) clock cycles and the HIGH phase lasts D*(H+1) clock cycles. The output changes only on a prescaler tick on which the counter is zero.
- R4: Control bits [1:0] pick the divide ratio for both channels: 00 divides by 1, 01 by 4, 10 by 16, 11 by 64. The prescaler produces no tick while its channel is stopped.
- R5: Control bit 4 inverts channel 0 and control bit 5 inverts channel 1; inversion also applies to the idle level and takes effect on the cycle after the write.
- R6: Clearing a channel's enable bit returns its output to the idle level (low before inversion) by the second cycle after the write; a later start begins again with a full LOW phase.
- R7: A reload write made while a channel runs does not alter the phase in progress; it is used the next time that phase is loaded.
- R8: A one-cycle high level on start input trig[i] sets channel i's enable bit, with the same timing as a software write of that bit.
- R9: Control bits [3:2] select the mode. 10 is the wide mode: channel 0 uses the 16-bit LOW width {reg 2, reg 0} and HIGH width {reg 3, reg 1}, and channel 1's output stays at its idle level. Codes 00, 01 and 11 run both channels as independent 8-bit generators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| trig | input | 2 | External start, one bit per channel |
| pulse_out | output | 2 | Pulse outputs, one bit per channel |

## Verification
The bench builds the block with its default parameters: 8-bit reload registers, a two-bit clock select with divide steps of four, and so a 16-bit counter for the wide mode. These values bring every divide ratio up to 64 and a 16-bit LOW width of 258 within a short run, while an 8-bit reload of 255 exercises the top of the single-channel range. Phase lengths are measured at the output as run lengths and compared with D*(reload+1), including runs that follow reload writes made mid-phase, a stop and a restart, and a start from the external input.

// File: rtl/pgen_pkg.sv
// Package: shared constants and types for the high/low width pulse generator.
// Assumes a byte-oriented write port with the address map given below.
package pgen_pkg;

    // Number of channels in one generator pair.
    localparam int NCH = 2;

    // Register addresses.
    localparam logic [2:0] ADDR_CTRL = 3'd4;
    localparam logic [2:0] ADDR_EN   = 3'd5;

    // Operating modes held in control bits [3:2].
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_DUAL   = 2'b01,
        MODE_WIDE   = 2'b10,
        MODE_SPARE  = 2'b11
    } pgen_mode_e;

    // Control bit positions.
    localparam int CTRL_CS_LSB   = 0;
    localparam int CTRL_MODE_LSB = 2;
    localparam int CTRL_REV_LSB  = 4;

endpackage

// File: rtl/pgen_prescale.sv
// Module: pgen_prescale
// Divides the base clock into a one-cycle tick. The select code k picks a
// ratio of 2**(STEP*k). The divider is cleared while its channel is stopped,
// so the first tick after a start comes a full ratio later.
module pgen_prescale #(
    parameter int CSW  = 2,
    parameter int STEP = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [CSW-1:0] csel,
    output logic           tick
);
    localparam int PRE_W = STEP * ((1 << CSW) - 1);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    // Mask of low divider bits that must all be one for a tick.
    always_comb begin
        for (int b = 0; b < PRE_W; b++) begin
            mask[b] = (b < int'(csel) * STEP);
        end
    end

    // Free-running divider, held at zero while the channel is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Tick when all selected low bits are set.
    assign tick = run && ((div_q & mask) == mask);

endmodule

// File: rtl/pgen_phase_ctr.sv
// Module: pgen_phase_ctr
// Down counter that alternates a LOW phase and a HIGH phase. On start it
// loads the LOW reload; on each tick it decrements, and at zero it flips the
// phase and loads the reload of the next phase. Reloads are sampled only at
// load time. Assumes en is a registered enable.
module pgen_phase_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] low_rl,
    input  logic [CW-1:0] high_rl,
    input  logic          rev,
    output logic          running,
    output logic          phase_hi,
    output logic [CW-1:0] cnt,
    output logic          pulse
);

    // Phase sequencing and counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running  <= 1'b0;
            phase_hi <= 1'b0;
            cnt      <= '0;
        end else if (!running) begin
            running  <= 1'b1;
            phase_hi <= 1'b0;
            cnt      <= low_rl;
        end else if (tick) begin
            if (cnt == '0) begin
                phase_hi <= ~phase_hi;
                cnt      <= phase_hi ? low_rl : high_rl;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Output level: idle low when stopped, then optional inversion.
    assign pulse = (running & phase_hi) ^ rev;

endmodule

// File: rtl/pgen_regs.sv
// Module: pgen_regs
// Write-only register file: per-channel LOW/HIGH reloads, the control byte
// fields and the enable bits. External start inputs set enable bits.
// Assumes DW is at least 6 so the control fields fit in one word.
module pgen_regs
    import pgen_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 3,
    parameter int CSW = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [NCH-1:0]          trig,
    output logic [NCH-1:0][DW-1:0]  low_q,
    output logic [NCH-1:0][DW-1:0]  high_q,
    output logic [CSW-1:0]          csel_q,
    output pgen_mode_e              mode_q,
    output logic [NCH-1:0]          rev_q,
    output logic [NCH-1:0]          en_q
);

    // One LOW and one HIGH reload per channel, at addresses 2i and 2i+1.
    for (genvar i = 0; i < NCH; i++) begin : g_reload
        localparam logic [AW-1:0] LO_ADDR = AW'(2 * i);
        localparam logic [AW-1:0] HI_ADDR = AW'(2 * i + 1);

        // Reload register writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                low_q[i]  <= '0;
                high_q[i] <= '0;
            end else if (wr_en) begin
                if (wr_addr == LO_ADDR) low_q[i]  <= wr_data;
                if (wr_addr == HI_ADDR) high_q[i] <= wr_data;
            end
        end
    end

    // Control fields: clock select, mode and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel_q <= '0;
            mode_q <= MODE_SINGLE;
            rev_q  <= '0;
        end else if (wr_en && wr_addr == AW'(ADDR_CTRL)) begin
            csel_q <= wr_data[CTRL_CS_LSB +: CSW];
            mode_q <= pgen_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
            rev_q  <= wr_data[CTRL_REV_LSB +: NCH];
        end
    end

    // Enable bits: software write, then external start sets bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_addr == AW'(ADDR_EN)) begin
            en_q <= wr_data[NCH-1:0] | trig;
        end else begin
            en_q <= en_q | trig;
        end
    end

endmodule

// File: rtl/pgen_pair.sv
// Module: pgen_pair (top)
// Two high/low width pulse generator channels sharing a clock select and a
// mode field. In wide mode channel 0 counts 16-bit widths built from both
// channels' reloads and channel 1 is held stopped.
module pgen_pair
    import pgen_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 3,
    parameter int CSW  = 2,
    parameter int STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH-1:0]    trig,
    output logic [NCH-1:0]    pulse_out
);
    localparam int CW = 2 * DW;

    logic [NCH-1:0][DW-1:0] low_q;
    logic [NCH-1:0][DW-1:0] high_q;
    logic [CSW-1:0]         csel_q;
    pgen_mode_e             mode_q;
    logic [NCH-1:0]         rev_q;
    logic [NCH-1:0]         en_q;

    logic                   wide;
    logic [NCH-1:0]         en_eff;
    logic [NCH-1:0][CW-1:0] low_rl;
    logic [NCH-1:0][CW-1:0] high_rl;
    logic [NCH-1:0]         tick;
    logic [NCH-1:0]         running;
    logic [NCH-1:0]         phase_hi;
    logic [NCH-1:0][CW-1:0] cnt;

    pgen_regs #(
        .DW  (DW),
        .AW  (AW),
        .CSW (CSW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .trig    (trig),
        .low_q   (low_q),
        .high_q  (high_q),
        .csel_q  (csel_q),
        .mode_q  (mode_q),
        .rev_q   (rev_q),
        .en_q    (en_q)
    );

    assign wide = (mode_q == MODE_WIDE);

    // Reload selection: channel 0 widens in wide mode; the upper channel of
    // the pair is held stopped while it lends its registers.
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        if (i == 0) begin : g_lead
            assign low_rl[i]  = wide ? {low_q[1], low_q[0]}   : CW'(low_q[0]);
            assign high_rl[i] = wide ? {high_q[1], high_q[0]} : CW'(high_q[0]);
            assign en_eff[i]  = en_q[i];
        end else begin : g_follow
            assign low_rl[i]  = CW'(low_q[i]);
            assign high_rl[i] = CW'(high_q[i]);
            assign en_eff[i]  = en_q[i] & ~wide;
        end

        pgen_prescale #(
            .CSW  (CSW),
            .STEP (STEP)
        ) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (running[i]),
            .csel  (csel_q),
            .tick  (tick[i])
        );

        pgen_phase_ctr #(
            .CW (CW)
        ) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_eff[i]),
            .tick     (tick[i]),
            .low_rl   (low_rl[i]),
            .high_rl  (high_rl[i]),
            .rev      (rev_q[i]),
            .running  (running[i]),
            .phase_hi (phase_hi[i]),
            .cnt      (cnt[i]),
            .pulse    (pulse_out[i])
        );
    end

endmodule

// File: rtl/pgen_pair_chk.sv
// Module: pgen_pair_chk
// Property checker for pgen_pair, attached by the bind statement below.
module pgen_pair_chk #(
    parameter int NCH = 2,
    parameter int CW  = 16,
    parameter int CSW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         en_eff,
    input  logic [NCH-1:0]         running,
    input  logic [NCH-1:0]         phase_hi,
    input  logic [NCH-1:0]         tick,
    input  logic [NCH-1:0][CW-1:0] cnt,
    input  logic [CSW-1:0]         csel_q,
    input  logic [1:0]             mode_q,
    input  logic [NCH-1:0]         rev_q,
    input  logic [NCH-1:0]         pulse_out
);

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> pulse_out == '0); // R1

    AST_WIDE_FOLLOWER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10 && $past(mode_q) == 2'b10) |-> pulse_out[1] == rev_q[1]); // R9

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(running[i]) |-> !phase_hi[i]); // R2

        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            (running[i] && en_eff[i] && !tick[i]) |=> $stable(phase_hi[i])); // R3

        AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (running[i] && en_eff[i] && cnt[i] != '0) |=> $stable(phase_hi[i])); // R3

        AST_TICK_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
            (running[i] && csel_q == '0) |-> tick[i]); // R4

        AST_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            !running[i] |-> !tick[i]); // R4

        AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_eff[i] && !$past(en_eff[i])) |-> pulse_out[i] == rev_q[i]); // R6
    end

endmodule

bind pgen_pair pgen_pair_chk #(
    .NCH (pgen_pkg::NCH),
    .CW  (CW),
    .CSW (CSW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_eff    (en_eff),
    .running   (running),
    .phase_hi  (phase_hi),
    .tick      (tick),
    .cnt       (cnt),
    .csel_q    (csel_q),
    .mode_q    (mode_q),
    .rev_q     (rev_q),
    .pulse_out (pulse_out)
);

// File: tb/pgen_pair_test.sv
// Bench for pgen_pair: a table of single-channel settings walked by one loop,
// then directed tests for reset, reload timing, stop, trigger and modes.
module pgen_pair_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] trig = '0;
    logic [1:0] pulse_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pgen_pair uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .trig      (trig),
        .pulse_out (pulse_out)
    );

    typedef struct packed {
        logic [1:0] cs;
        logic       rev;
        logic [7:0] lo;
        logic [7:0] hi;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{cs: 2'd0, rev: 1'b0, lo: 8'd3,   hi: 8'd5},
        '{cs: 2'd0, rev: 1'b0, lo: 8'd0,   hi: 8'd0},
        '{cs: 2'd1, rev: 1'b0, lo: 8'd2,   hi: 8'd1},
        '{cs: 2'd2, rev: 1'b1, lo: 8'd1,   hi: 8'd0},
        '{cs: 2'd3, rev: 1'b0, lo: 8'd0,   hi: 8'd1},
        '{cs: 2'd0, rev: 1'b1, lo: 8'd255, hi: 8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write commits at the next posedge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Measure a run at the idle level, a run at the active level and a
    // second idle run, sampling at negedges.
    task automatic measure3(input int ch, input logic idle,
                            output int r0, output int r1, output int r2);
        int seg = 0;
        int runs [3] = '{0, 0, 0};
        for (int k = 0; k < 40000 && seg < 3; k++) begin
            logic lvl;
            @(negedge clk);
            lvl = (seg == 1) ? ~idle : idle;
            if (pulse_out[ch] == lvl) begin
                runs[seg]++;
            end else begin
                seg++;
                if (seg < 3) runs[seg] = 1;
            end
        end
        r0 = runs[0];
        r1 = runs[1];
        r2 = runs[2];
    endtask

    initial begin
        int r0, r1, r2, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, outputs low and stay low.
        check("R1 outputs after reset", pulse_out, 0);
        repeat (4) @(negedge clk);
        check("R1 outputs remain idle", pulse_out, 0);

        // R1: reset reloads are zero and divide is 1, so a start toggles.
        wr(3'd5, 8'h01);
        measure3(0, 1'b0, r0, r1, r2);
        check("R1 low run with zero reload", r0, 1);
        check("R1 high run with zero reload", r1, 1);
        wr(3'd5, 8'h00);
        @(negedge clk);

        // R3 R4 R5: table of settings on channel 0.
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd4, {2'b00, 1'b0, VECS[v].rev, 2'b00, VECS[v].cs});
            wr(3'd0, VECS[v].lo);
            wr(3'd1, VECS[v].hi);
            check("R5 idle level follows polarity", pulse_out[0], VECS[v].rev);
            wr(3'd5, 8'h01);
            measure3(0, VECS[v].rev, r0, r1, r2);
            d = 1 << (2 * VECS[v].cs);
            check("R3 R4 first LOW phase", r0, d * (VECS[v].lo + 1));
            check("R3 R4 HIGH phase", r1, d * (VECS[v].hi + 1));
            check("R3 R4 second LOW phase", r2, d * (VECS[v].lo + 1));
            wr(3'd5, 8'h00);
            @(negedge clk);
        end

        // R5: polarity applies to idle outputs one cycle after the write.
        wr(3'd4, 8'h30);
        check("R5 both outputs inverted when idle", pulse_out, 3);
        wr(3'd4, 8'h00);
        check("R5 inversion removed", pulse_out, 0);

        // R6: stop during HIGH, then restart from a full LOW phase.
        wr(3'd0, 8'd2);
        wr(3'd1, 8'd9);
        wr(3'd5, 8'h01);
        repeat (4) @(negedge clk);
        check("R2 HIGH after LOW phase of 3", pulse_out[0], 1);
        wr(3'd5, 8'h00);
        @(negedge clk);
        check("R6 idle two cycles after stop", pulse_out[0], 0);
        repeat (5) @(negedge clk);
        check("R6 stays idle while stopped", pulse_out[0], 0);
        wr(3'd5, 8'h01);
        measure3(0, 1'b0, r0, r1, r2);
        check("R6 restart LOW phase", r0, 3);
        check("R6 restart HIGH phase", r1, 10);
        wr(3'd5, 8'h00);
        @(negedge clk);

        // R7: reload writes during the first LOW phase.
        wr(3'd0, 8'd4);
        wr(3'd1, 8'd6);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'd1);
        wr(3'd1, 8'd2);
        measure3(0, 1'b0, r0, r1, r2);
        check("R7 LOW phase in progress keeps old width", r0, 3);
        check("R7 next HIGH uses new width", r1, 3);
        check("R7 next LOW uses new width", r2, 2);
        wr(3'd5, 8'h00);
        @(negedge clk);

        // R8: external start on channel 1.
        wr(3'd2, 8'd2);
        wr(3'd3, 8'd1);
        trig = 2'b10;
        @(negedge clk);
        trig = 2'b00;
        measure3(1, 1'b0, r0, r1, r2);
        check("R8 triggered LOW phase", r0, 3);
        check("R8 triggered HIGH phase", r1, 2);
        check("R8 channel 0 untouched", pulse_out[0], 0);
        wr(3'd5, 8'h00);
        @(negedge clk);

        // R9: wide mode, 16-bit widths on channel 0, channel 1 idle.
        wr(3'd4, 8'h08);
        wr(3'd0, 8'd2);
        wr(3'd1, 8'd3);
        wr(3'd2, 8'd1);
        wr(3'd3, 8'd0);
        wr(3'd5, 8'h03);
        measure3(0, 1'b0, r0, r1, r2);
        check("R9 wide LOW phase", r0, 259);
        check("R9 wide HIGH phase", r1, 4);
        check("R9 wide second LOW phase", r2, 259);
        check("R9 channel 1 idle in wide mode", pulse_out[1], 0);
        wr(3'd5, 8'h00);
        @(negedge clk);

        // R9: mode 01 runs channel 1 on its own 8-bit reloads.
        wr(3'd4, 8'h04);
        wr(3'd5, 8'h02);
        measure3(1, 1'b0, r0, r1, r2);
        check("R9 mode 01 channel 1 LOW", r0, 2);
        check("R9 mode 01 channel 1 HIGH", r1, 1);
        wr(3'd5, 8'h00);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule